// File: doc/BRIEF.md
# Tiled Surface Address Generator

This unit converts a position inside a two-dimensional surface, given as a byte column and a row, into a byte offset from the start of the surface. Four memory layouts can be selected: a plain linear layout and three tiled layouts. In every tiled layout the surface is cut into 4096-byte tiles. The tiles are numbered row by row across the surface, and each tile orders its bytes in its own way: row-major for X tiles, column-major 16-byte units for Y tiles, and a nested quad order for W tiles.

An optional address swizzle flips bit 6 of a tiled offset according to higher offset bits. The pitch is the surface width in bytes. For any tiled layout it has to be a whole number of tile widths, and the unit raises an error flag when it is not. One request is accepted per clock on a valid strobe, and its result appears on the next cycle.

The layout select works like a small state. At reset the unit sits in LINEAR. Each accepted request moves it to the layout named by `mode`: LINEAR (00), XMAJOR (01), YMAJOR (10) or WMAJOR (11). While `in_valid` is low it stays in its current layout and holds its inputs.

Top module: `tsa_addr_gen`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high for the following cycle and `offset`/`pitch_err` hold that request's result. When `in_valid` is low, `out_valid` is low on the next cycle, and `offset` and `pitch_err` keep their previous values.
- R2: After reset, `out_valid`, `offset` and `pitch_err` are all 0.
- R3: With mode 00 (linear), `offset` = y·pitch + x. The swizzle enable has no effect and `pitch_err` is 0 for any pitch.
- R4: With mode 01 (X tile, 512 bytes × 8 rows), `offset` = ((y/8)·(pitch/512) + x/512)·4096 + (y mod 8)·512 + (x mod 512).
- R5: With mode 10 (Y tile, 128 bytes × 32 rows), the 16-byte unit number is ((x mod 128)/16)·32 + (y mod 32), and `offset` = ((y/32)·(pitch/128) + x/128)·4096 + unit·16 + (x mod 16).
- R6: With mode 11 (W tile, 64 bytes × 64 rows), `offset` = ((y/64)·(pitch/64) + x/64)·4096 + blk8·64 + blk4·16 + blk2·4 + blk1. Here blk8 = ((x mod 64)/8)·8 + (y mod 64)/8, and for k = 2, 1, 0 the quad index is y bit k · 2 + x bit k (blk4, blk2, blk1).
- R7: In mode 01 with `swz_en` = 1, bit 6 of the offset is replaced by bit6 XOR bit9 XOR bit10 of the unswizzled offset.
- R8: In modes 10 and 11 with `swz_en` = 1, bit 6 of the offset is replaced by bit6 XOR bit9. No other offset bit changes in any mode.
- R9: `pitch_err` is 1 when the pitch is not a multiple of 512 (mode 01), 128 (mode 10) or 64 (mode 11). The offset is still produced from the given pitch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe; inputs are captured on this cycle |
| x | input | X_W | Byte column inside the surface |
| y | input | Y_W | Row inside the surface |
| pitch | input | P_W | Surface pitch in bytes |
| mode | input | 2 | Layout: 00 linear, 01 X tile, 10 Y tile, 11 W tile |
| swz_en | input | 1 | Enable the bit-6 address swizzle |
| out_valid | output | 1 | Result valid, one cycle after the request |
| offset | output | X_W+Y_W... see note: Y_W+P_W | Byte offset from the surface base |
| pitch_err | output | 1 | Pitch not a multiple of the selected tile width |

## Verification
The hardest cases to reach are the swizzle corners. The flip of bit 6 depends on offset bits 9 and 10, and those bits are not inputs; they come out of the intra-tile mapping. The stimulus therefore picks coordinates whose mapped offset sets exactly one of bits 9 and 10, or both of them, so that both the flipping and the cancelling XOR are seen. The hold behaviour is checked by changing every input while the strobe is low and confirming that the result does not move.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
    typedef enum logic [1:0] {
        LAY_LINEAR = 2'b00,
        LAY_XMAJOR = 2'b01,
        LAY_YMAJOR = 2'b10,
        LAY_WMAJOR = 2'b11
    } layout_e;

    localparam int TILE_SHIFT = 12;
    localparam int SWZ_BIT    = 6;
endpackage

// File: rtl/tsa_tile_map.sv
module tsa_tile_map
    import tsa_pkg::*;
#(
    parameter int X_W   = 16,
    parameter int Y_W   = 16,
    parameter int P_W   = 16,
    parameter int OFF_W = Y_W + P_W
) (
    input  layout_e          lay,
    input  logic [X_W-1:0]   x,
    input  logic [Y_W-1:0]   y,
    input  logic [P_W-1:0]   pitch,
    output logic [OFF_W-1:0] raw_off
);
    logic [3:0]       row_sh;
    logic [3:0]       col_sh;
    logic [Y_W-1:0]   row_idx;
    logic [P_W-1:0]   tiles_row;
    logic [X_W-1:0]   col_idx;
    logic [OFF_W-1:0] base;
    logic [11:0]      intra;

    always_comb begin
        unique case (lay)
            LAY_LINEAR: begin row_sh = 4'd0; col_sh = 4'd0; end
            LAY_XMAJOR: begin row_sh = 4'd3; col_sh = 4'd9; end
            LAY_YMAJOR: begin row_sh = 4'd5; col_sh = 4'd7; end
            LAY_WMAJOR: begin row_sh = 4'd6; col_sh = 4'd6; end
        endcase
    end

    // one shared multiplier serves every layout
    assign row_idx   = y >> row_sh;
    assign tiles_row = pitch >> col_sh;
    assign col_idx   = x >> col_sh;
    assign base      = OFF_W'(row_idx) * OFF_W'(tiles_row) + OFF_W'(col_idx);

    always_comb begin
        unique case (lay)
            LAY_LINEAR: intra = 12'd0;
            LAY_XMAJOR: intra = {y[2:0], x[8:0]};
            LAY_YMAJOR: intra = {x[6:4], y[4:0], x[3:0]};
            LAY_WMAJOR: intra = {x[5:3], y[5:3], y[2], x[2], y[1], x[1], y[0], x[0]};
        endcase
    end

    assign raw_off = (lay == LAY_LINEAR) ? base
                                         : ((base << TILE_SHIFT) | OFF_W'(intra));
endmodule

// File: rtl/tsa_swizzle.sv
module tsa_swizzle
    import tsa_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  layout_e          lay,
    input  logic             en,
    input  logic [OFF_W-1:0] off_in,
    output logic [OFF_W-1:0] off_out
);
    logic flip;

    always_comb begin
        unique case (lay)
            LAY_LINEAR: flip = 1'b0;
            LAY_XMAJOR: flip = off_in[9] ^ off_in[10];
            LAY_YMAJOR: flip = off_in[9];
            LAY_WMAJOR: flip = off_in[9];
        endcase
    end

    always_comb begin
        off_out          = off_in;
        off_out[SWZ_BIT] = off_in[SWZ_BIT] ^ (en & flip);
    end
endmodule

// File: rtl/tsa_pitch_chk.sv
module tsa_pitch_chk
    import tsa_pkg::*;
#(
    parameter int P_W = 16
) (
    input  layout_e        lay,
    input  logic [P_W-1:0] pitch,
    output logic           bad
);
    always_comb begin
        unique case (lay)
            LAY_LINEAR: bad = 1'b0;
            LAY_XMAJOR: bad = |pitch[8:0];
            LAY_YMAJOR: bad = |pitch[6:0];
            LAY_WMAJOR: bad = |pitch[5:0];
        endcase
    end
endmodule

// File: rtl/tsa_addr_gen.sv
module tsa_addr_gen
    import tsa_pkg::*;
#(
    parameter int X_W = 16,
    parameter int Y_W = 16,
    parameter int P_W = 16,
    localparam int OFF_W = Y_W + P_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [X_W-1:0]   x,
    input  logic [Y_W-1:0]   y,
    input  logic [P_W-1:0]   pitch,
    input  logic [1:0]       mode,
    input  logic             swz_en,
    output logic             out_valid,
    output logic [OFF_W-1:0] offset,
    output logic             pitch_err
);
    layout_e          lay_q;
    logic [X_W-1:0]   x_q;
    logic [Y_W-1:0]   y_q;
    logic [P_W-1:0]   pitch_q;
    logic             swz_q;
    logic             vld_q;
    logic [OFF_W-1:0] raw_off;

    // layout state register: moves only on an accepted request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lay_q   <= LAY_LINEAR;
            x_q     <= '0;
            y_q     <= '0;
            pitch_q <= '0;
            swz_q   <= 1'b0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                lay_q   <= layout_e'(mode);
                x_q     <= x;
                y_q     <= y;
                pitch_q <= pitch;
                swz_q   <= swz_en;
            end
        end
    end

    tsa_tile_map #(.X_W(X_W), .Y_W(Y_W), .P_W(P_W), .OFF_W(OFF_W)) u_map (
        .lay(lay_q), .x(x_q), .y(y_q), .pitch(pitch_q), .raw_off(raw_off)
    );

    tsa_swizzle #(.OFF_W(OFF_W)) u_swz (
        .lay(lay_q), .en(swz_q), .off_in(raw_off), .off_out(offset)
    );

    tsa_pitch_chk #(.P_W(P_W)) u_chk (
        .lay(lay_q), .pitch(pitch_q), .bad(pitch_err)
    );

    assign out_valid = vld_q;

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(offset) && $stable(pitch_err)));
    a_r3_linear_noerr: assert property (@(posedge clk) disable iff (!rst_n)
        (lay_q == LAY_LINEAR) |-> !pitch_err);
    a_r3_linear_noswz: assert property (@(posedge clk) disable iff (!rst_n)
        (lay_q == LAY_LINEAR) |-> (offset == raw_off));
    a_r8_only_bit6: assert property (@(posedge clk) disable iff (!rst_n)
        ((offset ^ raw_off) & ~(OFF_W'(1) << SWZ_BIT)) == '0);
    a_r4_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && lay_q == LAY_XMAJOR) |-> (offset[5:0] == x_q[5:0]));
endmodule

// File: tb/tsa_addr_gen_tb.sv
`timescale 1ns/1ps
module tsa_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] x = '0;
    logic [15:0] y = '0;
    logic [15:0] pitch = '0;
    logic [1:0]  mode = '0;
    logic        swz_en = 1'b0;
    logic        out_valid;
    logic [31:0] offset;
    logic        pitch_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tsa_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x), .y(y),
        .pitch(pitch), .mode(mode), .swz_en(swz_en),
        .out_valid(out_valid), .offset(offset), .pitch_err(pitch_err)
    );

    localparam int NV = 15;
    localparam int VM[NV] = '{0, 1, 1, 1, 2, 2, 3, 3, 3, 1, 2, 3, 3, 0, 0};
    localparam int VS[NV] = '{1, 0, 1, 1, 0, 1, 0, 0, 1, 0, 0, 0, 0, 0, 1};
    localparam int VX[NV] = '{5, 531, 0, 64, 53, 16, 13, 70, 8, 0, 0, 0, 0, 2, 512};
    localparam int VY[NV] = '{3, 10, 2, 3, 40, 0, 22, 65, 0, 0, 0, 0, 0, 4, 0};
    localparam int VP[NV] = '{100, 1024, 512, 512, 256, 128, 128, 128, 64, 640, 192, 96, 64, 3, 1};
    localparam int VO[NV] = '{305, 13331, 1088, 1600, 9861, 576, 697, 12310, 576, 0, 0, 0, 0, 14, 512};
    localparam int VE[NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0};
    // requirement covered by each vector: R3 R4 R7 R7 R5 R8 R6 R6 R8 R9 R9 R9 R9 R3 R3
    localparam int VR[NV] = '{3, 4, 7, 7, 5, 8, 6, 6, 8, 9, 9, 9, 9, 3, 3};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic issue(input int m, input int s, input int xv, input int yv, input int pv);
        @(negedge clk);
        in_valid = 1'b1;
        mode   = 2'(m);
        swz_en = s[0];
        x      = 16'(xv);
        y      = 16'(yv);
        pitch  = 16'(pv);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        // R2: reset state
        #1;
        check("R2 out_valid", 32'(out_valid), 32'd0);
        check("R2 offset", offset, 32'd0);
        check("R2 pitch_err", 32'(pitch_err), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 out_valid after reset", 32'(out_valid), 32'd0);

        for (int i = 0; i < NV; i++) begin
            issue(VM[i], VS[i], VX[i], VY[i], VP[i]);
            check($sformatf("R%0d valid v%0d", VR[i], i), 32'(out_valid), 32'd1);
            check($sformatf("R%0d offset v%0d", VR[i], i), offset, 32'(VO[i]));
            check($sformatf("R%0d err v%0d", VR[i], i), 32'(pitch_err), 32'(VE[i]));
        end

        // R1: result holds while no request; inputs change but are ignored
        issue(1, 0, 531, 10, 1024);
        mode = 2'd3; x = 16'd999; y = 16'd77; pitch = 16'd100; swz_en = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 32'(out_valid), 32'd0);
        check("R1 hold offset", offset, 32'd13331);
        check("R1 hold err", 32'(pitch_err), 32'd0);
        repeat (3) @(negedge clk);
        check("R1 hold offset later", offset, 32'd13331);

        // R1: back-to-back requests, one result per cycle
        @(negedge clk);
        in_valid = 1'b1; mode = 2'd0; swz_en = 1'b0; x = 16'd1; y = 16'd2; pitch = 16'd10;
        @(negedge clk);
        check("R1 b2b first", offset, 32'd21);
        mode = 2'd2; x = 16'd16; y = 16'd0; pitch = 16'd128; swz_en = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check("R5 b2b second", offset, 32'd512);
        check("R1 b2b valid", 32'(out_valid), 32'd1);

        // R9 hold of error flag while idle
        issue(2, 0, 0, 0, 192);
        pitch = 16'd128;
        @(negedge clk);
        check("R9 err held", 32'(pitch_err), 32'd1);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule